// File: doc/BRIEF.md
# Bit-Manipulation Execution Unit

This block is a purely combinational execution unit for a 64-bit integer core. It covers the basic bit-manipulation group. The caller presents an operation code, two source operands and a word-mode flag, and the 64-bit result is valid in the same cycle.

The unit supports these operation families:

- bit counting;
- complemented logic;
- signed and unsigned minimum/maximum;
- narrow sign and zero extension;
- rotation;
- two whole-register byte operations: byte reversal and a per-byte nonzero mask.

The word-mode flag selects the 32-bit forms of the counts and rotates. In those forms only the low half of each operand is used. Counts come back zero-extended. Rotates come back sign-extended from bit 31. The flag has no effect on any other operation.

Inside, a small decoder turns the operation code into a packed strobe word. The strobe word picks a functional unit, a sub-operation and the effective word mode. The datapath holds a counting unit, a rotator and the remaining logic, and it muxes the unit outputs into the result. Codes that no operation uses produce zero.

Top module: `bmu_alu`

## Requirements
- R1: Code 0 returns the number of leading zeros and code 1 the number of trailing zeros of `rs1`; with `wordMode` low an all-zero operand gives 64.
- R2: With `wordMode` high, codes 0 and 1 count only within `rs1[31:0]` (bits 63:32 ignored), an all-zero low half gives 32, and the result is zero-extended.
- R3: Code 2 returns the number of one bits of `rs1`; with `wordMode` high only bits 31:0 are counted and the count is zero-extended.
- R4: Code 3 gives `rs1 & ~rs2`, code 4 gives `rs1 | ~rs2`, code 5 gives `~(rs1 ^ rs2)`.
- R5: Codes 6 and 7 return the smaller and larger operand in two's-complement order; codes 8 and 9 return the smaller and larger operand compared as unsigned 64-bit values.
- R6: Code 10 replicates bit 7 of `rs1` over bits 63:8, code 11 replicates bit 15 over bits 63:16, code 12 clears bits 63:16; `wordMode` has no effect on codes 3 to 12, 15 and 16.
- R7: Code 13 rotates `rs1` left and code 14 rotates it right, with `wordMode` low, by `rs2[5:0]` places within 64 bits.
- R8: With `wordMode` high, codes 13 and 14 rotate `rs1[31:0]` within 32 bits by `rs2[4:0]` and sign-extend bit 31 of the rotated value over bits 63:32.
- R9: Code 15 reverses the order of the eight bytes of `rs1` (byte 0 goes to byte 7).
- R10: Code 16 sets each result byte to 0xFF where the matching byte of `rs1` is nonzero and to 0x00 where it is zero.
- R11: Codes 17 to 31 produce an all-zero result regardless of operands and `wordMode`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opSel | input | 5 | Operation code (see requirements) |
| rs1 | input | 64 | First source operand |
| rs2 | input | 64 | Second source operand (rotate amount for rotates) |
| wordMode | input | 1 | Selects the 32-bit form of counts and rotates |
| result | output | 64 | Operation result |

## Verification
The bench builds the unit with its default 64-bit operand width, so the word forms cut the operand exactly at bit 32. At that width the all-zero count limits of 64 and 32, rotate amounts with bit 5 set, and the sign extension from bit 31 are all reachable. Random operands are drawn from sparse, dense and mixed patterns so that byte-level zero detection and counts close to both ends are exercised. Directed vectors are added for equal operands in min/max, rotation by zero and by the full width, and unused codes with word mode set.

// File: rtl/bmu_pkg.sv
package bmu_pkg;

  typedef enum logic [4:0] {
    OP_CLZ   = 5'd0,
    OP_CTZ   = 5'd1,
    OP_CPOP  = 5'd2,
    OP_ANDN  = 5'd3,
    OP_ORN   = 5'd4,
    OP_XNOR  = 5'd5,
    OP_MIN   = 5'd6,
    OP_MAX   = 5'd7,
    OP_MINU  = 5'd8,
    OP_MAXU  = 5'd9,
    OP_SEXTB = 5'd10,
    OP_SEXTH = 5'd11,
    OP_ZEXTH = 5'd12,
    OP_ROL   = 5'd13,
    OP_ROR   = 5'd14,
    OP_REV8  = 5'd15,
    OP_ORCB  = 5'd16
  } bmuOp_e;

  typedef enum logic [2:0] {
    U_NONE   = 3'd0,
    U_COUNT  = 3'd1,
    U_LOGIC  = 3'd2,
    U_MINMAX = 3'd3,
    U_EXT    = 3'd4,
    U_ROT    = 3'd5,
    U_BYTE   = 3'd6
  } bmuUnit_e;

  // Sub-select meaning per unit:
  //   count : 0 leading, 1 trailing, 2 population
  //   logic : 0 and-not, 1 or-not, 2 xnor
  //   minmax: bit0 = take larger, bit1 = unsigned compare
  //   ext   : 0 byte sign, 1 half sign, 2 half zero
  //   rot   : 0 left, 1 right
  //   byte  : 0 reverse, 1 or-combine
  typedef struct packed {
    bmuUnit_e   unit;
    logic [1:0] sub;
    logic       wordMode;
  } bmuStrobe_t;

endpackage

// File: rtl/bmu_ctrl.sv
module bmu_ctrl
  import bmu_pkg::*;
(
  input  logic [4:0]  opSel,
  input  logic        wordMode,
  output bmuStrobe_t  strobe
);

  always_comb begin
    strobe = '{unit: U_NONE, sub: 2'd0, wordMode: 1'b0};
    case (opSel)
      OP_CLZ:   strobe = '{unit: U_COUNT,  sub: 2'd0, wordMode: wordMode};
      OP_CTZ:   strobe = '{unit: U_COUNT,  sub: 2'd1, wordMode: wordMode};
      OP_CPOP:  strobe = '{unit: U_COUNT,  sub: 2'd2, wordMode: wordMode};
      OP_ANDN:  strobe = '{unit: U_LOGIC,  sub: 2'd0, wordMode: 1'b0};
      OP_ORN:   strobe = '{unit: U_LOGIC,  sub: 2'd1, wordMode: 1'b0};
      OP_XNOR:  strobe = '{unit: U_LOGIC,  sub: 2'd2, wordMode: 1'b0};
      OP_MIN:   strobe = '{unit: U_MINMAX, sub: 2'd0, wordMode: 1'b0};
      OP_MAX:   strobe = '{unit: U_MINMAX, sub: 2'd1, wordMode: 1'b0};
      OP_MINU:  strobe = '{unit: U_MINMAX, sub: 2'd2, wordMode: 1'b0};
      OP_MAXU:  strobe = '{unit: U_MINMAX, sub: 2'd3, wordMode: 1'b0};
      OP_SEXTB: strobe = '{unit: U_EXT,    sub: 2'd0, wordMode: 1'b0};
      OP_SEXTH: strobe = '{unit: U_EXT,    sub: 2'd1, wordMode: 1'b0};
      OP_ZEXTH: strobe = '{unit: U_EXT,    sub: 2'd2, wordMode: 1'b0};
      OP_ROL:   strobe = '{unit: U_ROT,    sub: 2'd0, wordMode: wordMode};
      OP_ROR:   strobe = '{unit: U_ROT,    sub: 2'd1, wordMode: wordMode};
      OP_REV8:  strobe = '{unit: U_BYTE,   sub: 2'd0, wordMode: 1'b0};
      OP_ORCB:  strobe = '{unit: U_BYTE,   sub: 2'd1, wordMode: 1'b0};
      default:  strobe = '{unit: U_NONE,   sub: 2'd0, wordMode: 1'b0};
    endcase
  end

endmodule

// File: rtl/bmu_count.sv
module bmu_count #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] src,
  input  logic [1:0]      kind,
  input  logic            wordMode,
  output logic [XLEN-1:0] cnt
);

  localparam int HALF = XLEN / 2;
  localparam int CW   = $clog2(XLEN) + 1;

  logic [XLEN-1:0] lzVec, tzVec, popVec;
  logic [CW-1:0]   lzCnt, tzCnt, popCnt;

  // Ones padded below (leading) or above (trailing) the low half cap the
  // count at HALF in word mode without a separate limit stage.
  always_comb begin
    lzVec  = wordMode ? {src[HALF-1:0], {HALF{1'b1}}} : src;
    tzVec  = wordMode ? {{HALF{1'b1}}, src[HALF-1:0]} : src;
    popVec = wordMode ? {{HALF{1'b0}}, src[HALF-1:0]} : src;
  end

  always_comb begin
    lzCnt = CW'(XLEN);
    for (int i = 0; i < XLEN; i++) begin
      if (lzVec[i]) lzCnt = CW'(XLEN - 1 - i);
    end
  end

  always_comb begin
    tzCnt = CW'(XLEN);
    for (int i = XLEN - 1; i >= 0; i--) begin
      if (tzVec[i]) tzCnt = CW'(i);
    end
  end

  always_comb begin
    popCnt = '0;
    for (int i = 0; i < XLEN; i++) begin
      popCnt = popCnt + CW'(popVec[i]);
    end
  end

  always_comb begin
    case (kind)
      2'd0:    cnt = XLEN'(lzCnt);
      2'd1:    cnt = XLEN'(tzCnt);
      default: cnt = XLEN'(popCnt);
    endcase
  end

endmodule

// File: rtl/bmu_rotate.sv
module bmu_rotate #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0]         src,
  input  logic [$clog2(XLEN)-1:0] amtSrc,
  input  logic                    dirRight,
  input  logic                    wordMode,
  output logic [XLEN-1:0]         rotOut
);

  localparam int HALF = XLEN / 2;
  localparam int SHW  = $clog2(XLEN);

  logic [SHW-1:0]    amt;
  logic [XLEN-1:0]   base;
  logic [2*XLEN-1:0] dbl, dblL, dblR;
  logic [XLEN-1:0]   rawRot;

  // In word mode the low half is duplicated, so a full-width rotate by an
  // amount below HALF leaves the 32-bit rotate in each half.
  always_comb begin
    amt    = wordMode ? {1'b0, amtSrc[SHW-2:0]} : amtSrc;
    base   = wordMode ? {src[HALF-1:0], src[HALF-1:0]} : src;
    dbl    = {base, base};
    dblL   = dbl << amt;
    dblR   = dbl >> amt;
    rawRot = dirRight ? dblR[XLEN-1:0] : dblL[2*XLEN-1:XLEN];
    rotOut = wordMode ? {{HALF{rawRot[HALF-1]}}, rawRot[HALF-1:0]} : rawRot;
  end

endmodule

// File: rtl/bmu_datapath.sv
module bmu_datapath
  import bmu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  bmuStrobe_t      strobe,
  input  logic [XLEN-1:0] rs1,
  input  logic [XLEN-1:0] rs2,
  output logic [XLEN-1:0] result
);

  localparam int NBYTES = XLEN / 8;
  localparam int SHW    = $clog2(XLEN);

  logic [XLEN-1:0] cntOut, rotOut, revOut, orcOut;
  logic [XLEN-1:0] logicOut, mmOut, extOut;
  logic            lessThan, pickFirst;

  bmu_count #(.XLEN(XLEN)) u_count (
    .src      (rs1),
    .kind     (strobe.sub),
    .wordMode (strobe.wordMode),
    .cnt      (cntOut)
  );

  bmu_rotate #(.XLEN(XLEN)) u_rotate (
    .src      (rs1),
    .amtSrc   (rs2[SHW-1:0]),
    .dirRight (strobe.sub[0]),
    .wordMode (strobe.wordMode),
    .rotOut   (rotOut)
  );

  for (genvar b = 0; b < NBYTES; b++) begin : g_bytes
    assign revOut[8*b +: 8] = rs1[8*(NBYTES-1-b) +: 8];
    assign orcOut[8*b +: 8] = {8{|rs1[8*b +: 8]}};
  end

  always_comb begin
    case (strobe.sub)
      2'd0:    logicOut = rs1 & ~rs2;
      2'd1:    logicOut = rs1 | ~rs2;
      default: logicOut = ~(rs1 ^ rs2);
    endcase
  end

  always_comb begin
    lessThan  = strobe.sub[1] ? (rs1 < rs2) : ($signed(rs1) < $signed(rs2));
    pickFirst = strobe.sub[0] ? ~lessThan : lessThan;
    mmOut     = pickFirst ? rs1 : rs2;
  end

  always_comb begin
    case (strobe.sub)
      2'd0:    extOut = {{(XLEN-8){rs1[7]}}, rs1[7:0]};
      2'd1:    extOut = {{(XLEN-16){rs1[15]}}, rs1[15:0]};
      default: extOut = {{(XLEN-16){1'b0}}, rs1[15:0]};
    endcase
  end

  always_comb begin
    case (strobe.unit)
      U_COUNT:  result = cntOut;
      U_LOGIC:  result = logicOut;
      U_MINMAX: result = mmOut;
      U_EXT:    result = extOut;
      U_ROT:    result = rotOut;
      U_BYTE:   result = strobe.sub[0] ? orcOut : revOut;
      default:  result = '0;
    endcase
  end

endmodule

// File: rtl/bmu_alu.sv
module bmu_alu
  import bmu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [4:0]      opSel,
  input  logic [XLEN-1:0] rs1,
  input  logic [XLEN-1:0] rs2,
  input  logic            wordMode,
  output logic [XLEN-1:0] result
);

  bmuStrobe_t strobe;

  bmu_ctrl u_ctrl (
    .opSel    (opSel),
    .wordMode (wordMode),
    .strobe   (strobe)
  );

  bmu_datapath #(.XLEN(XLEN)) u_dp (
    .strobe (strobe),
    .rs1    (rs1),
    .rs2    (rs2),
    .result (result)
  );

endmodule

// File: rtl/bmu_alu_chk.sv
module bmu_alu_chk #(
  parameter int XLEN = 64
) (
  input logic [4:0]      opSel,
  input logic [XLEN-1:0] rs1,
  input logic [XLEN-1:0] rs2,
  input logic            wordMode,
  input logic [XLEN-1:0] result
);

  localparam int HALF = XLEN / 2;

  always_comb begin
    if (opSel > 5'd16) begin
      a_r11_unused_zero: assert (result == '0)
        else $error("unused code gives nonzero result");
    end
    if ((opSel <= 5'd2) && !wordMode) begin
      a_r1_count_range: assert (result <= XLEN)
        else $error("full count out of range");
    end
    if ((opSel <= 5'd2) && wordMode) begin
      a_r2_word_count_range: assert (result <= HALF)
        else $error("word count out of range");
    end
    if (opSel == 5'd5) begin
      a_r4_xnor_relation: assert ((result ^ rs1 ^ rs2) == '1)
        else $error("xnor relation broken");
    end
    if ((opSel >= 5'd6) && (opSel <= 5'd9)) begin
      a_r5_pick_operand: assert ((result == rs1) || (result == rs2))
        else $error("min/max result is neither operand");
    end
    if ((opSel == 5'd13 || opSel == 5'd14) && wordMode) begin
      a_r8_word_sign_ext: assert (result[XLEN-1:HALF] == {HALF{result[HALF-1]}})
        else $error("word rotate not sign extended");
    end
    if (opSel == 5'd16) begin
      for (int b = 0; b < XLEN / 8; b++) begin
        a_r10_byte_saturated: assert ((result[8*b +: 8] == 8'h00) || (result[8*b +: 8] == 8'hFF))
          else $error("or-combine byte not saturated");
      end
    end
  end

endmodule

bind bmu_alu bmu_alu_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/bmu_alu_bench.sv
module bmu_alu_bench;

  logic        clk = 1'b0;
  logic [4:0]  opSel = '0;
  logic [63:0] rs1 = '0;
  logic [63:0] rs2 = '0;
  logic        wordMode = 1'b0;
  logic [63:0] result;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;  // 250 MHz

  bmu_alu u_bmu_alu (
    .opSel    (opSel),
    .rs1      (rs1),
    .rs2      (rs2),
    .wordMode (wordMode),
    .result   (result)
  );

  function automatic string reqOf(int op, logic w);
    case (op)
      0, 1:          return w ? "R2" : "R1";
      2:             return "R3";
      3, 4, 5:       return "R4";
      6, 7, 8, 9:    return "R5";
      10, 11, 12:    return "R6";
      13, 14:        return w ? "R8" : "R7";
      15:            return "R9";
      16:            return "R10";
      default:       return "R11";
    endcase
  endfunction

  function automatic logic [63:0] refModel(int op, logic [63:0] a, logic [63:0] b, logic w);
    logic [63:0] r;
    int width, k, n;
    width = w ? 32 : 64;
    r = '0;
    case (op)
      0: begin
        n = 0;
        for (int i = width - 1; i >= 0; i--) begin
          if (a[i]) break;
          n++;
        end
        r = 64'(n);
      end
      1: begin
        n = 0;
        for (int i = 0; i < width; i++) begin
          if (a[i]) break;
          n++;
        end
        r = 64'(n);
      end
      2: begin
        n = 0;
        for (int i = 0; i < width; i++) n += int'(a[i]);
        r = 64'(n);
      end
      3: r = a & ~b;
      4: r = a | ~b;
      5: r = ~(a ^ b);
      6: r = ($signed(a) < $signed(b)) ? a : b;
      7: r = ($signed(a) > $signed(b)) ? a : b;
      8: r = (a < b) ? a : b;
      9: r = (a > b) ? a : b;
      10: begin
        r = a;
        for (int i = 8; i < 64; i++) r[i] = a[7];
      end
      11: begin
        r = a;
        for (int i = 16; i < 64; i++) r[i] = a[15];
      end
      12: r = {48'h0, a[15:0]};
      13, 14: begin
        k = w ? int'(b[4:0]) : int'(b[5:0]);
        for (int i = 0; i < width; i++) begin
          if (op == 13) r[(i + k) % width] = a[i];
          else          r[i] = a[(i + k) % width];
        end
        if (w) for (int i = 32; i < 64; i++) r[i] = r[31];
      end
      15: for (int i = 0; i < 8; i++) r[8*i +: 8] = a[8*(7-i) +: 8];
      16: for (int i = 0; i < 8; i++) r[8*i +: 8] = (a[8*i +: 8] != 0) ? 8'hFF : 8'h00;
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic applyVec(int op, logic [63:0] a, logic [63:0] b, logic w);
    logic [63:0] exp;
    @(posedge clk);
    opSel = 5'(op);
    rs1 = a;
    rs2 = b;
    wordMode = w;
    exp = refModel(op, a, b, w);
    @(negedge clk);
    checks++;
    if (result !== exp) begin
      fails++;
      $display("FAIL %s op=%0d w=%0b a=%h b=%h actual=%h expected=%h",
               reqOf(op, w), op, w, a, b, result, exp);
    end
  endtask

  task automatic checkConst(string req, int op, logic [63:0] a, logic [63:0] b,
                            logic w, logic [63:0] exp);
    @(posedge clk);
    opSel = 5'(op);
    rs1 = a;
    rs2 = b;
    wordMode = w;
    @(negedge clk);
    checks++;
    if (result !== exp) begin
      fails++;
      $display("FAIL %s op=%0d actual=%h expected=%h", req, op, result, exp);
    end
  endtask

  function automatic logic [63:0] pattern(int kind);
    logic [63:0] v;
    v = {$urandom(), $urandom()};
    case (kind)
      0: return v & {$urandom(), $urandom()} & {$urandom(), $urandom()};
      1: return v | {$urandom(), $urandom()};
      2: return 64'h1 << ($urandom() % 64);
      default: return v;
    endcase
  endfunction

  initial begin
    void'($urandom(32'd7121));
    // R11 idle state: unused code 31 with everything zero gives zero
    checkConst("R11", 31, 64'h0, 64'h0, 1'b0, 64'h0);
    checkConst("R1", 0, 64'h0, 64'h0, 1'b0, 64'd64);
    checkConst("R1", 1, 64'h0, 64'h0, 1'b0, 64'd64);
    checkConst("R1", 0, 64'h1, 64'h0, 1'b0, 64'd63);
    checkConst("R2", 0, 64'hFFFF_FFFF_0000_0000, 64'h0, 1'b1, 64'd32);
    checkConst("R2", 1, 64'hFFFF_FFFF_0000_0000, 64'h0, 1'b1, 64'd32);
    checkConst("R2", 0, 64'h0000_0000_0000_8000, 64'h0, 1'b1, 64'd16);
    checkConst("R3", 2, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b0, 64'd64);
    checkConst("R3", 2, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b1, 64'd32);
    checkConst("R4", 3, 64'hF0F0, 64'hFF00, 1'b0, 64'h00F0);
    checkConst("R5", 6, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF);
    checkConst("R5", 8, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 1'b0, 64'h1);
    checkConst("R5", 7, 64'h5, 64'h5, 1'b0, 64'h5);
    checkConst("R6", 10, 64'h80, 64'h0, 1'b1, 64'hFFFF_FFFF_FFFF_FF80);
    checkConst("R6", 12, 64'hFFFF_FFFF_FFFF_8001, 64'h0, 1'b1, 64'h8001);
    checkConst("R6", 3, 64'hFFFF_FFFF_0000_0000, 64'h0, 1'b1, 64'hFFFF_FFFF_0000_0000);
    checkConst("R7", 13, 64'h8000_0000_0000_0001, 64'd64, 1'b0, 64'h8000_0000_0000_0001);
    checkConst("R7", 14, 64'h1, 64'd1, 1'b0, 64'h8000_0000_0000_0000);
    checkConst("R8", 14, 64'hABCD_0000_0000_0001, 64'd33, 1'b1, 64'hFFFF_FFFF_8000_0000);
    checkConst("R8", 13, 64'h0000_0000_4000_0000, 64'd0, 1'b1, 64'h0000_0000_4000_0000);
    checkConst("R9", 15, 64'h0102_0304_0506_0708, 64'h0, 1'b0, 64'h0807_0605_0403_0201);
    checkConst("R10", 16, 64'h0100_0000_8000_0001, 64'h0, 1'b0, 64'hFF00_0000_FF00_00FF);
    checkConst("R11", 20, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF, 1'b1, 64'h0);
    for (int n = 0; n < 3000; n++) begin
      applyVec(int'($urandom() % 32), pattern(int'($urandom() % 4)),
               pattern(int'($urandom() % 4)), 1'($urandom()));
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule